// File: doc/BRIEF.md
# Packed Lane Compare, Min/Max and Average ALU

This block performs one SIMD operation per cycle on two 64-bit operands that are split into equal lanes of 8, 16 or 32 bits. It covers lane-mask compares (equality, signed greater-than and unsigned greater-than), signed and unsigned minimum and maximum, wrapping add and subtract, and a byte or halfword average with a caller-supplied rounding bit. Every lane is computed on its own. No carry, borrow or comparison result crosses a lane boundary.

A request is presented with `in_valid` high for one cycle. The 64-bit result and a 32-bit per-lane status word are registered and appear one cycle later with `out_valid`. The status word holds a negative flag and a zero flag per lane. Their positions depend on the lane size. After an average, only the zero flags are reported. Combinations the unit cannot execute give an all-zero result and status together with a one-cycle `op_err` pulse. These are a word-size average, the reserved size code, and the reserved opcodes.

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `result`, `status`, `out_valid` and `op_err` are cleared to zero at that edge.
- R2: A request accepted with `in_valid` high gives `out_valid` high on the next cycle. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `result` and `status` unchanged.
- R3: Size codes are 0 for 8-bit lanes, 1 for 16-bit lanes, 2 for 32-bit lanes, and 3 is reserved. Opcodes 0 (equal), 1 (signed greater-than) and 2 (unsigned greater-than) compare a against b in each lane. A lane is all ones where the condition holds and all zeros where it does not.
- R4: The selection opcodes copy one whole lane of a or b into the result, choosing by lane comparison. They are opcode 3 (signed minimum), 4 (unsigned minimum), 5 (signed maximum) and 6 (unsigned maximum).
- R5: Opcode 7 (add) and opcode 8 (subtract, a minus b) wrap modulo 2^lane-width in each lane. No carry or borrow passes into the neighbouring lane.
- R6: Opcode 9 (average) gives (a + b + round_bit) >> 1 per 8-bit or 16-bit lane. The sum is formed one bit wider than the lane, so it does not overflow.
- R7: For opcodes 0 to 8, lane k sets a negative flag (copy of the lane's top bit) and a zero flag (lane equals zero). Their positions depend on the lane size. For 8-bit lanes they are bits 4k+3 and 4k+2. For 16-bit lanes they are bits 8k+7 and 8k+6. For 32-bit lanes they are bits 16k+15 and 16k+14. All other status bits are zero.
- R8: After an average, only the zero flags are set, at bit 4k+2 for 8-bit lanes and at bit 8k+6 for 16-bit lanes. Every negative flag and every other status bit is zero.
- R9: Some requests are illegal: an average with size code 2, size code 3, or an opcode from 10 to 15. Such a request gives a zero result, a zero status and `op_err` high on the next cycle. A legal request gives `op_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe, one operation per high cycle |
| op_code | input | 4 | Operation select (encoding in R3 to R6, R9) |
| elem_size | input | 2 | Lane size select (encoding in R3) |
| round_bit | input | 1 | Rounding addend for the average |
| opa | input | 64 | First operand, a |
| opb | input | 64 | Second operand, b |
| out_valid | output | 1 | Result and status are fresh this cycle |
| result | output | 64 | Registered packed result |
| status | output | 32 | Registered per-lane negative and zero flags |
| op_err | output | 1 | One-cycle pulse for an illegal request |

## Verification
The properties assume that `op_code`, `elem_size` and the operands carry known values whenever `in_valid` is high. They also assume that `in_valid` stays low while reset is applied, so the first result is never in flight across reset. The stimulus changes inputs only on the falling clock edge and lowers `in_valid` between requests. It drives the reserved size and opcode values only in the directed illegal-request cases. The vectors place 0x80, 0x7F, 0xFF and 0x00 in adjacent lanes, and place carries and borrows at lane edges. A wrong signed/unsigned choice or a lane leak therefore changes the expected mask, selected lane or wrapped sum.

// File: rtl/simd_alu_pkg.sv
// Shared encodings for the packed lane ALU.
// Assumes the opcode and size fields keep the widths declared here.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_CMP_EQ  = 4'd0,
        OP_CMP_GTS = 4'd1,
        OP_CMP_GTU = 4'd2,
        OP_MIN_S   = 4'd3,
        OP_MIN_U   = 4'd4,
        OP_MAX_S   = 4'd5,
        OP_MAX_U   = 4'd6,
        OP_ADD     = 4'd7,
        OP_SUB     = 4'd8,
        OP_AVG     = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } elem_size_e;

    localparam int unsigned NUM_SIZES = 3;
    localparam int unsigned BASE_LANE_W = 8;

    // True when the request can be executed by the lane datapath.
    function automatic logic req_is_legal(input logic [3:0] op, input logic [1:0] sz);
        logic ok;
        ok = (sz != SZ_RSVD) && (op <= OP_AVG);
        if (op == OP_AVG && sz == SZ_WORD) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/simd_lane_op.sv
// One lane of the packed ALU: computes a single operation on LANE_W-bit
// operands. Pure combinational; assumes op is a defined opcode or it
// returns zero.
module simd_lane_op
    import simd_alu_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  logic [3:0]        op,
    input  logic              rnd,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res
);

    logic [LANE_W:0] wide_sum;
    logic            s_gt;
    logic            u_gt;
    logic            is_eq;

    // Widened sum for the average so the carry out is kept.
    assign wide_sum = {1'b0, a} + {1'b0, b} + {{LANE_W{1'b0}}, rnd};
    assign s_gt     = $signed(a) > $signed(b);
    assign u_gt     = a > b;
    assign is_eq    = (a == b);

    // Lane operation select.
    always_comb begin
        case (alu_op_e'(op))
            OP_CMP_EQ:  res = {LANE_W{is_eq}};
            OP_CMP_GTS: res = {LANE_W{s_gt}};
            OP_CMP_GTU: res = {LANE_W{u_gt}};
            OP_MIN_S:   res = s_gt ? b : a;
            OP_MIN_U:   res = u_gt ? b : a;
            OP_MAX_S:   res = s_gt ? a : b;
            OP_MAX_U:   res = u_gt ? a : b;
            OP_ADD:     res = a + b;
            OP_SUB:     res = a - b;
            OP_AVG:     res = wide_sum[LANE_W:1];
            default:    res = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_array.sv
// Splits the DATA_W operands into DATA_W/LANE_W lanes and runs one
// simd_lane_op per lane. Assumes DATA_W is a multiple of LANE_W.
module simd_lane_array #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [3:0]        op,
    input  logic              rnd,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    localparam int unsigned LANES = DATA_W / LANE_W;

    // One independent lane unit per slice; nothing crosses a slice edge.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        simd_lane_op #(.LANE_W(LANE_W)) u_lane (
            .op  (op),
            .rnd (rnd),
            .a   (a[k*LANE_W +: LANE_W]),
            .b   (b[k*LANE_W +: LANE_W]),
            .res (res[k*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_flag_pack.sv
// Builds the per-lane status word: each lane owns STAT_W/LANES bits, with
// its negative flag in the top bit and zero flag just below. Assumes
// STAT_W is a multiple of the lane count and at least two bits per lane.
module simd_flag_pack #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned STAT_W = 32
) (
    input  logic [DATA_W-1:0] lane_res,
    input  logic              z_only,
    output logic [STAT_W-1:0] flags
);

    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned STRIDE = STAT_W / LANES;

    // Per-lane flag field: N on top, Z below, remaining bits zero.
    for (genvar k = 0; k < LANES; k++) begin : g_flag
        assign flags[k*STRIDE + STRIDE - 1] = !z_only && lane_res[k*LANE_W + LANE_W - 1];
        assign flags[k*STRIDE + STRIDE - 2] = (lane_res[k*LANE_W +: LANE_W] == '0);
        if (STRIDE > 2) begin : g_pad
            assign flags[k*STRIDE +: STRIDE-2] = '0;
        end
    end

endmodule

// File: rtl/simd_lane_alu.sv
// Packed lane ALU top: runs the operation at every supported lane size in
// parallel, picks the requested size, and registers result, status and an
// error pulse. Assumes in_valid qualifies op_code, elem_size and operands.
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        elem_size,
    input  logic              round_bit,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W/2-1:0] status,
    output logic              op_err
);

    localparam int unsigned STAT_W = DATA_W / 2;

    logic [DATA_W-1:0] res_by_size  [NUM_SIZES];
    logic [STAT_W-1:0] stat_by_size [NUM_SIZES];
    logic              is_avg;
    logic              legal;
    logic [DATA_W-1:0] sel_res;
    logic [STAT_W-1:0] sel_stat;

    assign is_avg = (op_code == OP_AVG);
    assign legal  = req_is_legal(op_code, elem_size);

    // One lane array and flag packer per lane size (8, 16, 32 bits).
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int unsigned LW = BASE_LANE_W << g;

        simd_lane_array #(.DATA_W(DATA_W), .LANE_W(LW)) u_arr (
            .op  (op_code),
            .rnd (round_bit),
            .a   (opa),
            .b   (opb),
            .res (res_by_size[g])
        );

        simd_flag_pack #(.DATA_W(DATA_W), .LANE_W(LW), .STAT_W(STAT_W)) u_flags (
            .lane_res (res_by_size[g]),
            .z_only   (is_avg),
            .flags    (stat_by_size[g])
        );
    end

    // Choose the requested lane size; illegal requests give zero.
    always_comb begin
        sel_res  = '0;
        sel_stat = '0;
        if (legal) begin
            case (elem_size_e'(elem_size))
                SZ_BYTE: begin sel_res = res_by_size[0]; sel_stat = stat_by_size[0]; end
                SZ_HALF: begin sel_res = res_by_size[1]; sel_stat = stat_by_size[1]; end
                SZ_WORD: begin sel_res = res_by_size[2]; sel_stat = stat_by_size[2]; end
                default: begin sel_res = '0;             sel_stat = '0;             end
            endcase
        end
    end

    // Output register stage: capture on in_valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_err    <= 1'b0;
            result    <= '0;
            status    <= '0;
        end else begin
            out_valid <= in_valid;
            op_err    <= in_valid && !legal;
            if (in_valid) begin
                result <= sel_res;
                status <= sel_stat;
            end
        end
    end

endmodule

// File: rtl/simd_lane_alu_chk.sv
// Property checker for simd_lane_alu, attached by bind. Assumes known
// inputs while in_valid is high and in_valid low during reset.
module simd_lane_alu_chk
    import simd_alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op_code,
    input logic [1:0]  elem_size,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        out_valid,
    input logic [63:0] result,
    input logic [31:0] status,
    input logic        op_err
);

    // True when every byte is either 0x00 or 0xFF.
    function automatic logic byte_masks(input logic [63:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    logic chk_legal;
    logic size_ok;
    assign chk_legal = (elem_size != 2'd3) && (op_code < 4'd10) &&
                       !(op_code == 4'd9 && elem_size == 2'd2);
    assign size_ok   = (elem_size != 2'd3);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(status)));

    assert_cmp_byte_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= 4'd2 && elem_size == 2'd0) |=> byte_masks(result));

    assert_eq_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'd0 && size_ok && opa == opb) |=> (result == '1));

    assert_minmax_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code >= 4'd3 && op_code <= 4'd6 && size_ok && opa == opb)
        |=> (result == $past(opa)));

    assert_sub_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'd8 && size_ok && opa == opb) |=> (result == '0));

    assert_byte_lane0_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= 4'd8 && elem_size == 2'd0)
        |=> (status[3] == result[7] && status[2] == (result[7:0] == 8'h00)));

    assert_avg_byte_zonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'd9 && elem_size == 2'd0)
        |=> ((status & ~32'h4444_4444) == 32'h0));

    assert_avg_half_zonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'd9 && elem_size == 2'd1)
        |=> ((status & ~32'h4040_4040) == 32'h0));

    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chk_legal) |=> (op_err && result == '0 && status == '0));

    assert_legal_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_legal) |=> !op_err);

endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .elem_size (elem_size),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result),
    .status    (status),
    .op_err    (op_err)
);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
// Self-checking bench: walks a table of hand-computed vectors, then
// directed reset, hold and illegal-request cases.
module simd_lane_alu_bench;

    localparam int CLK_HALF = 2;  // 250 MHz
    localparam int NV = 19;

    localparam logic [3:0] V_OP [NV] = '{
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd7, 4'd7,
        4'd8, 4'd8, 4'd9, 4'd9, 4'd9, 4'd0, 4'd1, 4'd4, 4'd5};
    localparam logic [1:0] V_SZ [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2,
        2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd1, 2'd2};
    localparam logic V_RND [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
        1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] V_A [NV] = '{
        64'h0011223344556677, 64'h807FFF0001807F05, 64'h807FFF0001807F05,
        64'h807FFF0001807F05, 64'h807FFF0001807F05, 64'h807FFF0001807F05,
        64'h807FFF0001807F05, 64'hFF0180FF7F000102, 64'hFFFF80007FFF0001,
        64'hFFFFFFFF00000001, 64'h00807F00100005FF, 64'h0000800000051234,
        64'hFFFF0001807F0300, 64'hFFFF0001807F0300, 64'hFFFF000080000001,
        64'h12340000FFFF00FF, 64'h800000007FFFFFFF, 64'h80007FFF0000FFFF,
        64'hFFFFFFFF00000000};
    localparam logic [63:0] V_B [NV] = '{
        64'h0011FF3300556600, 64'h7F8000FF0100FF04, 64'h7F8000FF0100FF04,
        64'h7F8000FF0100FF04, 64'h7F8000FF0100FF04, 64'h7F8000FF0100FF04,
        64'h7F8000FF0100FF04, 64'h01FF80010100FFFE, 64'h000180000001FFFF,
        64'h000000017FFFFFFF, 64'h0101FF00108006FF, 64'h0001000100061234,
        64'hFF00000080800401, 64'hFF00000080800401, 64'hFFFF000080010000,
        64'h12340001FFFFFF00, 64'h7FFFFFFF80000000, 64'h7FFF8000FFFF0001,
        64'h0000000180000000};
    localparam logic [63:0] V_RES [NV] = '{
        64'hFFFF00FF00FFFF00, 64'h00FF00FF0000FFFF, 64'hFF00FF0000FF00FF,
        64'h8080FFFF0180FF04, 64'h7F7F000001007F04, 64'h7F7F000001007F05,
        64'h8080FFFF0180FF05, 64'h0000000080000000, 64'h0000000080000000,
        64'h0000000080000000, 64'hFF7F80000080FF00, 64'hFFFF7FFFFFFF0000,
        64'hFF7F0000807F0300, 64'hFF80000180800401, 64'hFFFF000080010001,
        64'hFFFF0000FFFF0000, 64'h00000000FFFFFFFF, 64'h7FFF7FFF00000001,
        64'h0000000100000000};
    localparam logic [31:0] V_ST [NV] = '{
        32'h88484884, 32'h48484488, 32'h84844848, 32'h88880880, 32'h00440400,
        32'h00440400, 32'h88880880, 32'h44448444, 32'h40408040, 32'h40008000,
        32'h80844884, 32'h80008040, 32'h00440004, 32'h00400000, 32'h00400000,
        32'h80408040, 32'h40008000, 32'h00004000, 32'h00004000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  elem_size = '0;
    logic        round_bit = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] status;
    logic        op_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #CLK_HALF clk = ~clk;

    simd_lane_alu u_simd_lane_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .elem_size (elem_size),
        .round_bit (round_bit),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result),
        .status    (status),
        .op_err    (op_err)
    );

    function automatic string res_tag(input logic [3:0] op);
        if (op <= 4'd2) return "R3";
        if (op <= 4'd6) return "R4";
        if (op <= 4'd8) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request for a single cycle; outputs are sampled on the
    // falling edge after the capturing rising edge.
    task automatic run_op(input logic [3:0] op, input logic [1:0] sz, input logic rnd,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_code = op; elem_size = sz; round_bit = rnd; opa = a; opb = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 result", result, 64'h0);
        check("R1 status", {32'h0, status}, 64'h0);
        check("R1 valid/err", {62'h0, out_valid, op_err}, 64'h0);
        rst_n = 1'b1;

        // Table walk: R3..R8 with R9 error low for legal requests
        for (int i = 0; i < NV; i++) begin
            run_op(V_OP[i], V_SZ[i], V_RND[i], V_A[i], V_B[i]);
            check(res_tag(V_OP[i]), result, V_RES[i]);
            check((V_OP[i] == 4'd9) ? "R8 status" : "R7 status", {32'h0, status}, {32'h0, V_ST[i]});
            check("R2 out_valid", {63'h0, out_valid}, 64'h1);
            check("R9 no err", {63'h0, op_err}, 64'h0);
        end

        // R2: idle cycle with changed inputs leaves outputs held
        @(negedge clk);
        opa = 64'h1234567812345678; opb = 64'h0; op_code = 4'd7;
        @(negedge clk);
        check("R2 hold result", result, V_RES[NV-1]);
        check("R2 hold status", {32'h0, status}, {32'h0, V_ST[NV-1]});
        check("R2 valid low", {63'h0, out_valid}, 64'h0);

        // R9: average at word size
        run_op(4'd9, 2'd2, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h1111111111111111);
        check("R9 avg word result", result, 64'h0);
        check("R9 avg word status", {32'h0, status}, 64'h0);
        check("R9 avg word err", {63'h0, op_err}, 64'h1);
        @(negedge clk);
        check("R9 err one cycle", {63'h0, op_err}, 64'h0);

        // R9: reserved size code
        run_op(4'd7, 2'd3, 1'b0, 64'h0102030405060708, 64'h0102030405060708);
        check("R9 rsvd size result", result, 64'h0);
        check("R9 rsvd size err", {63'h0, op_err}, 64'h1);

        // R9: reserved opcode
        run_op(4'd12, 2'd0, 1'b0, 64'hFFFF, 64'h1);
        check("R9 rsvd op result", result, 64'h0);
        check("R9 rsvd op err", {63'h0, op_err}, 64'h1);

        // R5: borrow at every byte edge stays in lane (0x00 - 0x01 each lane)
        run_op(4'd8, 2'd0, 1'b0, 64'h0, 64'h0101010101010101);
        check("R5 sub no borrow chain", result, 64'hFFFFFFFFFFFFFFFF);
        check("R7 all negative", {32'h0, status}, 64'h88888888);

        // R6: halfword average without rounding of 0xFFFF pairs
        run_op(4'd9, 2'd1, 1'b0, 64'hFFFF0001FFFF0001, 64'hFFFF0000FFFF0000);
        check("R6 half avg r0", result, 64'hFFFF0000FFFF0000);
        check("R8 half avg z", {32'h0, status}, 64'h00400040);

        // R1: reset in the middle of a run clears outputs
        run_op(4'd0, 2'd0, 1'b0, 64'h5, 64'h5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset result", result, 64'h0);
        check("R1 mid reset status", {32'h0, status}, 64'h0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule